// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Sequencer

This block is the column-side controller of a four-bank synchronous DRAM model. It watches the active-low command strobes on each rising clock edge. A mode-set command stores a mode word taken from the address bus. That word selects the burst length, the beat ordering, the read latency and whether writes are burst or single-beat.

A read or write command captures a start column and a bank. The block then issues one column address per clock, with a valid flag, a write flag and a last-beat flag. A burst-stop command ends the current burst. A new read or write cancels the burst in flight and starts its own. Read beats come back out on a separate strobe, delayed by the programmed latency, to mark when read data would be on the bus.

Cell storage, row handling, refresh and electrical timing belong to other parts of the model.

Top module: `sdram_burst_seq`

## Requirements
- R1: Commands are decoded only on rising clock edges, with cs_n low. The strobe patterns {ras_n,cas_n,we_n} are: 000 mode set, 101 read, 100 write, 110 burst stop. After reset no burst is active, rd_valid is low, and the mode is burst length 1, sequential, latency 2, burst writes.
- R2: A read or write loads the start column from addr[COL_W-1:0] and the bank from bank. Beat 0 appears in the cycle after the command, with beat_bank equal to the captured bank, and one further beat follows each cycle.
- R3: The mode word sets the burst length in addr[2:0] (000=1, 001=2, 010=4, 011=8, 111=full page). In sequential order, beat n carries the start column with its low log2(BL) bits replaced by (start + n) mod BL.
- R4: addr[3]=1 selects interleaved order, in which beat n carries the start column with its low log2(BL) bits XORed with n. Full-page bursts are always sequential.
- R5: A full-page burst steps through every column, wrapping from the top column to 0. It continues until it is stopped or replaced, and it never raises beat_last.
- R6: beat_last is high on the final beat of a fixed-length burst, and beat_valid is low in the following cycle unless a new read or write was issued.
- R7: With addr[9]=1 in the mode word, every write carries exactly one beat, while reads keep the programmed length. With addr[9]=0, writes use the programmed length.
- R8: addr[6:4]=011 selects read latency 3, and any other value selects 2. rd_valid is high exactly CL cycles after each cycle in which a read beat is valid.
- R9: A burst-stop command makes beat_valid low from the next cycle.
- R10: A read or write issued during an active burst abandons the old burst. The new beat 0 appears in the next cycle.
- R11: Reserved burst-length codes (100, 101, 110) act as a burst length of 1.
- R12: When cs_n is high, all strobes and the address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (12) | Address bus: start column or mode word |
| bank | input | BANK_W (2) | Bank select |
| beat_col | output | COL_W (8) | Column address of the current beat |
| beat_bank | output | BANK_W (2) | Bank of the current beat |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_write | output | 1 | Current beat belongs to a write |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| rd_valid | output | 1 | Read beat data valid, CL cycles after the beat |

## Verification
The bench aims at starting columns that are not aligned to the burst length. A design that carried into the upper column bits, instead of wrapping inside the burst window, would give wrong addresses from the first wrap onward. It also covers the top-column wrap of a full-page burst and an abort in the middle of a burst, where a stale beat counter would skip or repeat columns. Latency changes between 2 and 3 and single-beat writes mixed with burst reads are exercised too: an off-by-one delay or a write that ignored the single-beat mode shows up at once on rd_valid or beat_last. Chip-select-high cycles carrying read strobes, and reserved length codes, check that nothing gets decoded that should not be.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_MODE,
      CMD_READ,
      CMD_WRITE,
      CMD_STOP
   } cmd_e;

   typedef struct packed {
      logic       full;     // full-page burst
      logic [1:0] bl_log;   // log2 of fixed burst length
      logic       ilv;      // interleaved ordering
      logic       cl3;      // read latency 3 (else 2)
      logic       wr_one;   // single-beat writes
   } mode_t;

   localparam mode_t MODE_RESET = '{full: 1'b0, bl_log: 2'd0, ilv: 1'b0,
                                    cl3: 1'b0, wr_one: 1'b0};

   localparam int MIN_CL = 2;
   localparam int MAX_CL = 3;

   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
      cmd_e c;
      c = CMD_NONE;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b000:  c = CMD_MODE;
            3'b101:  c = CMD_READ;
            3'b100:  c = CMD_WRITE;
            3'b110:  c = CMD_STOP;
            default: c = CMD_NONE;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
   import sdram_burst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_e       cmd,
   input  logic [9:0] word,
   output mode_t      mode
);

   mode_t next_mode;

   always_comb begin
      next_mode        = MODE_RESET;
      next_mode.ilv    = word[3];
      next_mode.cl3    = (word[6:4] == 3'b011);
      next_mode.wr_one = word[9];
      case (word[2:0])
         3'b001:  next_mode.bl_log = 2'd1;
         3'b010:  next_mode.bl_log = 2'd2;
         3'b011:  next_mode.bl_log = 2'd3;
         3'b111:  next_mode.full   = 1'b1;
         default: next_mode.bl_log = 2'd0;   // length 1, also reserved codes
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               mode <= MODE_RESET;
      else if (cmd == CMD_MODE) mode <= next_mode;
   end

   // R1: mode only moves on a mode-set command
   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cmd) != CMD_MODE) |-> $stable(mode));

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
   import sdram_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int BANK_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd,
   input  logic [COL_W-1:0]  start_col,
   input  logic [BANK_W-1:0] start_bank,
   input  mode_t             mode,
   output logic [COL_W-1:0]  beat_col,
   output logic [BANK_W-1:0] beat_bank,
   output logic              beat_valid,
   output logic              beat_write,
   output logic              beat_last
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic              active, is_wr, len_full, ilv_r;
   logic [COL_W-1:0]  mask, start, cnt, offset;
   logic [BANK_W-1:0] bank_r;
   logic              load, one_beat;

   assign load     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
   assign one_beat = (cmd == CMD_WRITE) && mode.wr_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         is_wr    <= 1'b0;
         len_full <= 1'b0;
         ilv_r    <= 1'b0;
         mask     <= '0;
         start    <= '0;
         cnt      <= '0;
         bank_r   <= '0;
      end else if (load) begin
         active   <= 1'b1;
         is_wr    <= (cmd == CMD_WRITE);
         len_full <= mode.full && !one_beat;
         ilv_r    <= mode.ilv && !mode.full;
         mask     <= one_beat  ? '0 :
                     mode.full ? '1 : (ONE << mode.bl_log) - ONE;
         start    <= start_col;
         cnt      <= '0;
         bank_r   <= start_bank;
      end else if (cmd == CMD_STOP) begin
         active <= 1'b0;
      end else if (active) begin
         if (beat_last) active <= 1'b0;
         else           cnt    <= cnt + ONE;
      end
   end

   assign offset     = ilv_r ? (start ^ cnt) : (start + cnt);
   assign beat_col   = (start & ~mask) | (offset & mask);
   assign beat_bank  = bank_r;
   assign beat_valid = active;
   assign beat_write = active && is_wr;
   assign beat_last  = active && !len_full && (cnt == mask);

   p_cnt_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !len_full) |-> ((cnt & ~mask) == '0));

   p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last && !load) |=> !beat_valid);

   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_STOP) |=> !beat_valid);

   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat_valid && beat_col == $past(start_col)
                && beat_bank == $past(start_bank)));

   p_single_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      one_beat |=> beat_last);

endmodule

// File: rtl/sdram_rd_delay.sv
module sdram_rd_delay
   import sdram_burst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic beat_rd,
   input  logic cl3,
   output logic rd_valid
);

   logic [MAX_CL-1:0] stage;

   always_ff @(posedge clk) begin
      if (!rst_n) stage[0] <= 1'b0;
      else        stage[0] <= beat_rd;
   end

   for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage[i] <= 1'b0;
         else        stage[i] <= stage[i-1];
      end
   end

   assign rd_valid = cl3 ? stage[MAX_CL-1] : stage[MIN_CL-1];

   p_lat3_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cl3 && $past(cl3) && $past(cl3, 2)) |-> (rd_valid == $past(beat_rd, 3)));

   p_lat2_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cl3 && !$past(cl3)) |-> (rd_valid == $past(beat_rd, 2)));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sdram_burst_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int COL_W  = 8,
   parameter int BANK_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output logic [COL_W-1:0]  beat_col,
   output logic [BANK_W-1:0] beat_bank,
   output logic              beat_valid,
   output logic              beat_write,
   output logic              beat_last,
   output logic              rd_valid
);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must hold the 10-bit mode word");
   end
   if (COL_W < 3 || COL_W > ADDR_W) begin : g_bad_col
      $error("COL_W must cover an 8-beat burst and fit the address bus");
   end

   cmd_e  cmd;
   mode_t mode;

   assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

   sdram_mode_reg u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .word  (addr[9:0]),
      .mode  (mode)
   );

   sdram_col_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_cols (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .start_col  (addr[COL_W-1:0]),
      .start_bank (bank),
      .mode       (mode),
      .beat_col   (beat_col),
      .beat_bank  (beat_bank),
      .beat_valid (beat_valid),
      .beat_write (beat_write),
      .beat_last  (beat_last)
   );

   sdram_rd_delay u_rdly (
      .clk      (clk),
      .rst_n    (rst_n),
      .beat_rd  (beat_valid && !beat_write),
      .cl3      (mode.cl3),
      .rd_valid (rd_valid)
   );

   p_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !beat_valid) |=> !beat_valid);

endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;

   localparam int ADDR_W = 12;
   localparam int COL_W  = 8;
   localparam int BANK_W = 2;
   localparam int NCOL   = 1 << COL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [BANK_W-1:0] bank = '0;
   logic [COL_W-1:0]  beat_col;
   logic [BANK_W-1:0] beat_bank;
   logic              beat_valid, beat_write, beat_last, rd_valid;

   always #10 clk = ~clk;   // 50 MHz

   sdram_burst_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .addr(addr), .bank(bank), .beat_col(beat_col),
      .beat_bank(beat_bank), .beat_valid(beat_valid), .beat_write(beat_write),
      .beat_last(beat_last), .rd_valid(rd_valid)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R1";

   task automatic check(input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int m_bl = 1, m_cl = 2;            // m_bl 0 means full page
   bit m_ilv = 0, m_single = 0;
   bit b_act = 0, b_wr = 0, b_ilv = 0;
   int b_cnt = 0, b_start = 0, b_len = 1, b_bank = 0;
   bit rd_hist [0:7];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bl = 1; m_cl = 2; m_ilv = 0; m_single = 0; b_act = 0;
      end else if (!cs_n && !ras_n && !cas_n && !we_n) begin
         case (addr[2:0])
            3'd1: m_bl = 2;
            3'd2: m_bl = 4;
            3'd3: m_bl = 8;
            3'd7: m_bl = 0;
            default: m_bl = 1;
         endcase
         m_ilv = addr[3];
         m_cl = (addr[6:4] == 3'd3) ? 3 : 2;
         m_single = addr[9];
         if (b_act) begin
            if (b_len != 0 && b_cnt == b_len - 1) b_act = 0; else b_cnt++;
         end
      end else if (!cs_n && ras_n && !cas_n) begin
         b_act = 1; b_cnt = 0; b_start = int'(addr[COL_W-1:0]);
         b_bank = int'(bank); b_wr = !we_n;
         b_len = (b_wr && m_single) ? 1 : m_bl;
         b_ilv = m_ilv;
      end else if (!cs_n && ras_n && cas_n && !we_n) begin
         b_act = 0;
      end else if (b_act) begin
         if (b_len != 0 && b_cnt == b_len - 1) b_act = 0; else b_cnt++;
      end
   end

   function automatic int exp_col();
      int base, off;
      if (b_len == 0) return (b_start + b_cnt) % NCOL;
      base = (b_start / b_len) * b_len;
      off  = b_start % b_len;
      if (b_ilv) return base + (off ^ b_cnt);
      return base + (off + b_cnt) % b_len;
   endfunction

   always @(negedge clk) begin
      for (int i = 7; i > 0; i--) rd_hist[i] = rd_hist[i-1];
      rd_hist[0] = rst_n && b_act && !b_wr;
      if (rst_n) begin
         check("beat_valid", int'(beat_valid), int'(b_act));
         if (b_act) begin
            check("beat_col",   int'(beat_col),   exp_col());
            check("beat_bank",  int'(beat_bank),  b_bank);
            check("beat_write", int'(beat_write), int'(b_wr));
            check("beat_last",  int'(beat_last),
                  int'(b_len != 0 && b_cnt == b_len - 1));
         end
         check("rd_valid", int'(rd_valid), int'(rd_hist[m_cl]));
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic c, input logic r, input logic ca,
                        input logic w, input int a, input int b);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w;
      addr = ADDR_W'(a); bank = BANK_W'(b);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 0, 0);
   endtask

   task automatic set_mode(input int bl, input int ilv, input int cl, input int one);
      drive(0, 0, 0, 0, (one << 9) | (cl << 4) | (ilv << 3) | bl, 0);
   endtask

   task automatic rd(input int col, input int b);
      drive(0, 1, 0, 1, col, b);
   endtask

   task automatic wr(input int col, input int b);
      drive(0, 1, 0, 0, col, b);
   endtask

   task automatic stop_burst();
      drive(0, 1, 1, 0, 0, 0);
   endtask

   bit done = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      cur_req = "R1";
      check("reset beat_valid", int'(beat_valid), 0);
      check("reset rd_valid", int'(rd_valid), 0);
      rd(37, 1); nop(5);                     // defaults: BL1 CL2

      cur_req = "R12";
      drive(1, 1, 0, 1, 9, 2); drive(1, 0, 0, 0, 3, 0); nop(3);
      rd(4, 0); nop(4);                      // mode still BL1

      cur_req = "R3";
      set_mode(1, 0, 2, 0); rd(5, 2); nop(5);
      set_mode(2, 0, 2, 0); rd(6, 3); nop(7);
      set_mode(3, 0, 2, 0); rd(45, 1); nop(10);
      wr(253, 2); nop(10);

      cur_req = "R4";
      set_mode(1, 1, 2, 0); rd(7, 0); nop(5);
      set_mode(2, 1, 2, 0); rd(6, 1); nop(7);
      set_mode(3, 1, 2, 0); rd(45, 2); nop(10);
      wr(2, 3); nop(10);

      cur_req = "R8";
      set_mode(3, 0, 3, 0); nop(4); rd(19, 1); nop(12);
      set_mode(2, 1, 3, 0); nop(4); rd(1, 0); rd(10, 2); nop(10);
      set_mode(2, 0, 2, 0); nop(6);

      cur_req = "R7";
      set_mode(3, 0, 2, 1); wr(12, 3); nop(4); rd(12, 3); nop(10);
      wr(0, 1); wr(1, 1); nop(4);
      set_mode(3, 0, 2, 0); wr(12, 2); nop(10);

      cur_req = "R6";
      set_mode(2, 0, 2, 0); rd(3, 0); nop(3); rd(8, 1); nop(6);

      cur_req = "R10";
      set_mode(3, 0, 2, 0); rd(2, 1); nop(2); rd(20, 2); nop(1); wr(99, 3); nop(10);

      cur_req = "R5";
      set_mode(7, 1, 2, 0); rd(NCOL - 3, 2); nop(NCOL + 5);

      cur_req = "R9";
      stop_burst(); nop(5);
      set_mode(3, 0, 2, 0); rd(16, 0); nop(2); stop_burst(); nop(5);

      cur_req = "R11";
      set_mode(4, 0, 1, 0); rd(30, 1); nop(4);
      set_mode(6, 1, 7, 0); rd(31, 2); nop(5);

      cur_req = "R2";
      set_mode(1, 0, 2, 0); rd(200, 3); wr(201, 0); nop(4);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule